// File: doc/BRIEF.md
# FP4 Block Dequantizer with Shared Power-of-Two Scale

This block expands one block of 32 packed 4-bit floating-point elements into 32 single-precision (FP32) words. Each element has 1 sign bit, a 2-bit exponent and a 1-bit mantissa. The whole block shares one 8-bit scale that holds only an exponent: it has no sign and no mantissa. The scale code `c` stands for the factor 2^(c-127).

The scale is applied by adding it to each element's exponent, so the block needs no multiplier. A whole block arrives in a single valid/ready transfer. The block then streams out one FP32 word per accepted beat and flags the final word. It does not take a new block until the current one has been fully drained.

Top module: `mx4_dequant`

## Requirements
- R1: While reset is held and just after reset, `outValid` is 0 and `inReady` is 1.
- R2: A block is taken on a cycle where `inValid` and `inReady` are both 1. From that edge until the last word of the block has been accepted, `inReady` stays 0, and anything presented on the input bus has no effect on the words that come out.
- R3: A taken block produces exactly 32 output words. Word k comes from the nibble at bits [4k+3:4k] of `inElems`, so the least significant nibble comes out first. The first word is valid in the cycle after the block is taken. After the 32nd word is accepted, `outValid` falls and `inReady` rises.
- R4: `outLast` is 1 on word 31 of a block and 0 on every other word.
- R5: For a normal element (bits [2:1] nonzero), with sign s = bit 3, exponent field E = bits [2:1] and mantissa bit m = bit 0, the output is {s, 8-bit biased exponent scale+E-1, m, 22 zero bits}. This applies whenever that biased exponent lies in 1..254.
- R6: Element magnitude code 3'b001 means 0.5. It gives biased exponent scale-1 and a zero mantissa.
- R7: Magnitude code 3'b000 gives a signed FP32 zero, {s, 31'b0}, for every scale code including 0xFF.
- R8: Scale code 0xFF turns every nonzero element of the block into the quiet NaN 32'h7FC00000.
- R9: When the biased exponent of a nonzero element would be 255 or more, the output is an infinity with the element's sign, {s, 8'hFF, 23'b0}.
- R10: When the biased exponent of a nonzero element would be 0 or below, the output is flushed to {s, 31'b0}.
- R11: While `outValid` is 1 and `outReady` is 0, `outData` and `outLast` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A block is presented |
| inReady | output | 1 | Block can be taken |
| inScale | input | 8 | Shared power-of-two scale code |
| inElems | input | 128 | 32 packed 4-bit elements, element 0 in bits [3:0] |
| outValid | output | 1 | Output word available |
| outReady | input | 1 | Consumer takes the word |
| outData | output | 32 | FP32 result |
| outLast | output | 1 | Marks word 31 of the block |

## Verification
The hardest conditions to reach are the exponent edges. Overflow to infinity and flush to zero only happen at the far ends of the scale range, and each block contains only a few element codes that cross them. The stimulus therefore sweeps all 256 scale codes, each in its own block. Block s places code (k+s) mod 16 at word k, so every element code meets every scale code across the sweep. A pseudo-random stall pattern on `outReady` exercises the hold behaviour. While a block is draining, the bench drives a different block as valid, so that ignoring a busy-time input is tested through the words that come out.

// File: rtl/mx4_dequant_pkg.sv
package mx4_dequant_pkg;
  localparam int ELEM_W  = 4;
  localparam int SCALE_W = 8;
  localparam int WORD_W  = 32;
  localparam logic [WORD_W-1:0] QNAN = 32'h7FC0_0000;

  typedef struct packed {
    logic load;
    logic advance;
  } dqStrobe_t;
endpackage

// File: rtl/mx4_dequant_ctrl.sv
module mx4_dequant_ctrl
  import mx4_dequant_pkg::*;
#(
  parameter int BLOCK_LEN = 32,
  localparam int IDX_W = $clog2(BLOCK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             outLast,
  output dqStrobe_t        strb,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);

  logic busy;
  logic atLast;

  assign atLast       = (idx == LAST_IDX);
  assign strb.load    = inValid && !busy;
  assign strb.advance = busy && outReady;
  assign inReady      = !busy;
  assign outValid     = busy;
  assign outLast      = busy && atLast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (strb.load) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (strb.advance) begin
      if (atLast) busy <= 1'b0;
      else        idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/mx4_dequant_dp.sv
module mx4_dequant_dp
  import mx4_dequant_pkg::*;
#(
  parameter int BLOCK_LEN = 32,
  localparam int IDX_W = $clog2(BLOCK_LEN),
  localparam int PACK_W = BLOCK_LEN * ELEM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dqStrobe_t          strb,
  input  logic [IDX_W-1:0]   idx,
  input  logic [SCALE_W-1:0] inScale,
  input  logic [PACK_W-1:0]  inElems,
  output logic [WORD_W-1:0]  outData
);
  logic [SCALE_W-1:0] scaleReg;
  logic [PACK_W-1:0]  elemReg;
  logic [ELEM_W-1:0]  lanes [BLOCK_LEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scaleReg <= '0;
      elemReg  <= '0;
    end else if (strb.load) begin
      scaleReg <= inScale;
      elemReg  <= inElems;
    end
  end

  for (genvar g = 0; g < BLOCK_LEN; g++) begin : g_lane
    assign lanes[g] = elemReg[g*ELEM_W +: ELEM_W];
  end

  logic [ELEM_W-1:0]  cur;
  logic               sgn;
  logic [1:0]         expFld;
  logic               mant;
  logic signed [9:0]  biased;

  assign cur    = lanes[idx];
  assign sgn    = cur[3];
  assign expFld = cur[2:1];
  // Subnormal 0.5 normalises to 1.0 x 2^-1: zero mantissa, same exponent sum.
  assign mant   = (expFld == 2'd0) ? 1'b0 : cur[0];
  assign biased = $signed({2'b00, scaleReg}) + $signed({8'd0, expFld}) - 10'sd1;

  always_comb begin
    if (cur[2:0] == 3'd0)
      outData = {sgn, 31'd0};
    else if (scaleReg == 8'hFF)
      outData = QNAN;
    else if (biased >= 10'sd255)
      outData = {sgn, 8'hFF, 23'd0};
    else if (biased <= 10'sd0)
      outData = {sgn, 31'd0};
    else
      outData = {sgn, biased[7:0], mant, 22'd0};
  end
endmodule

// File: rtl/mx4_dequant.sv
module mx4_dequant
  import mx4_dequant_pkg::*;
#(
  parameter int BLOCK_LEN = 32,
  localparam int IDX_W = $clog2(BLOCK_LEN),
  localparam int PACK_W = BLOCK_LEN * ELEM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  output logic               inReady,
  input  logic [SCALE_W-1:0] inScale,
  input  logic [PACK_W-1:0]  inElems,
  output logic               outValid,
  input  logic               outReady,
  output logic [WORD_W-1:0]  outData,
  output logic               outLast
);
  dqStrobe_t        strb;
  logic [IDX_W-1:0] idx;

  mx4_dequant_ctrl #(.BLOCK_LEN(BLOCK_LEN)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .outLast(outLast),
    .strb(strb), .idx(idx)
  );

  mx4_dequant_dp #(.BLOCK_LEN(BLOCK_LEN)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .idx(idx),
    .inScale(inScale), .inElems(inElems), .outData(outData)
  );
endmodule

// File: rtl/mx4_dequant_chk.sv
module mx4_dequant_chk #(
  parameter int BLOCK_LEN = 32,
  localparam int CNT_W = $clog2(BLOCK_LEN) + 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        outLast
);
  logic [CNT_W-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    beats <= '0;
    else if (inValid && inReady)   beats <= '0;
    else if (outValid && outReady) beats <= beats + 1'b1;
  end

  a_r2_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !inReady);

  a_r3_take_starts_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> (outValid && !outLast));

  a_r4_last_at_final_beat: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outLast == (beats == CNT_W'(BLOCK_LEN - 1))));

  a_r3_drain_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && outLast) |=> (!outValid && inReady));

  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));
endmodule

bind mx4_dequant mx4_dequant_chk #(.BLOCK_LEN(BLOCK_LEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast)
);

// File: tb/test_mx4_dequant.sv
module test_mx4_dequant;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [7:0]   inScale = '0;
  logic [127:0] inElems = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [31:0]  outData;
  logic         outLast;

  int total = 0;
  int bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  mx4_dequant i_mx4_dequant (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inScale(inScale), .inElems(inElems), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Value = mag2 * 2^(scale-128), mag2 = twice the element magnitude.
  function automatic logic [31:0] expWord(input logic [7:0] sc, input logic [3:0] nib);
    int c = int'(nib[2:0]);
    int mag2, p, b;
    logic m;
    if (c < 2) mag2 = c;
    else       mag2 = (2 + (c % 2)) << ((c / 2) - 1);
    if (mag2 == 0) return {nib[3], 31'd0};
    if (sc == 8'hFF) return 32'h7FC0_0000;
    p = (mag2 >= 8) ? 3 : (mag2 >= 4) ? 2 : (mag2 >= 2) ? 1 : 0;
    m = (p > 0) ? 1'((mag2 >> (p - 1)) & 1) : 1'b0;
    b = p + int'(sc) - 1;
    if (b >= 255) return {nib[3], 8'hFF, 23'd0};
    if (b <= 0)   return {nib[3], 31'd0};
    return {nib[3], 8'(b), m, 22'd0};
  endfunction

  function automatic string tagFor(input logic [7:0] sc, input logic [3:0] nib);
    int b;
    if (nib[2:0] == 3'd0) return "R7 R3";
    if (sc == 8'hFF) return "R8 R3";
    b = int'(nib[2:1]) + int'(sc) - 1;
    if (b >= 255) return "R9 R3";
    if (b <= 0) return "R10 R3";
    if (nib[2:0] == 3'd1) return "R6 R3";
    return "R5 R3";
  endfunction

  task automatic runBlock(input logic [7:0] sc, input logic [127:0] el);
    int k = 0;
    logic holdPend = 1'b0;
    logic [31:0] holdData = '0;
    logic holdLast = 1'b0;
    inScale = sc; inElems = el; inValid = 1'b1;
    check("R2 ready before take", 32'(inReady), 32'd1);
    @(negedge clk);
    inScale = ~sc; inElems = ~el;   // competing block while busy (R2)
    while (k < 32) begin
      if (holdPend) begin
        check("R11 data hold", outData, holdData);
        check("R11 last hold", 32'(outLast), 32'(holdLast));
      end
      check("R3 valid during drain", 32'(outValid), 32'd1);
      check("R2 not ready while busy", 32'(inReady), 32'd0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = lfsr[0] | lfsr[1];
      inValid = (k < 31);
      if (outReady) begin
        check(tagFor(sc, el[k*4 +: 4]), outData, expWord(sc, el[k*4 +: 4]));
        check("R4 last flag", 32'(outLast), 32'(k == 31));
        k++;
        holdPend = 1'b0;
      end else begin
        holdPend = 1'b1; holdData = outData; holdLast = outLast;
      end
      @(negedge clk);
    end
    outReady = 1'b0; inValid = 1'b0;
    check("R3 valid drops after block", 32'(outValid), 32'd0);
    check("R3 ready returns", 32'(inReady), 32'd1);
  endtask

  initial begin
    logic [127:0] el;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(outValid), 32'd0);
    check("R1 ready in reset", 32'(inReady), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 32'(outValid), 32'd0);
    check("R1 ready after reset", 32'(inReady), 32'd1);
    for (int s = 0; s < 256; s++) begin
      for (int i = 0; i < 32; i++) el[i*4 +: 4] = 4'((i + s) % 16);
      runBlock(8'(s), el);
    end
    // Extra patterns: all zeros of both signs under a NaN scale, and reversed codes.
    for (int i = 0; i < 32; i++) el[i*4 +: 4] = (i % 2 == 0) ? 4'h0 : 4'h8;
    runBlock(8'hFF, el);
    for (int i = 0; i < 32; i++) el[i*4 +: 4] = 4'(15 - (i % 16));
    runBlock(8'd127, el);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule